// File: doc/BRIEF.md
# Color Subcarrier Phase Generator

This block is the phase source for a composite or S-video chroma path. A 32-bit accumulator adds a programmed frequency word on every pixel clock. The top eight bits of the accumulator, plus a programmable hue offset, go to a downstream sine lookup. That lookup, the chroma modulator and the filters are not part of this block. For a 27 MHz pixel clock, the word 0x21F07C1F gives about 3.579545 MHz and the word 0x2A098ACB gives about 4.43361875 MHz.

The accumulator does not run freely forever. It can be reloaded to a start phase on a schedule. The start phase goes into the top eight bits and the lower bits are cleared. The schedule is picked by a two-bit interval setting: never, every second line, every second frame or every fourth frame. A timing generator supplies single-cycle line and frame strobes. Internal counters divide those strobes to find the reload points. The counters restart whenever the interval setting changes. Typical start phases are 0xF9 for 525-line timing, reloaded every two frames, and 0xD9 for 625-line timing, never reloaded. A burst-enable input decides whether the burst window is flagged downstream as carrying subcarrier.

Top module: `sc_phase_nco`

## Requirements
- R1: While rst_n is low at a rising edge, phase_out becomes 0, burst_on becomes 0 and the accumulator is loaded with start_phase in its top 8 bits and zeros below. The first output after release is start_phase + hue.
- R2: When no reload occurs, the accumulator grows by freq_word on each rising edge, modulo 2^32.
- R3: On a reload, the accumulator becomes {start_phase, 24'h0}.
- R4: With rst_interval = 0 (never), no reload ever occurs, whatever strobes arrive.
- R5: With rst_interval = 1, a reload occurs on every second line_pulse, counted from the last change of the setting.
- R6: With rst_interval = 2, a reload occurs on every second frame_pulse, counted from the last change of the setting.
- R7: With rst_interval = 3, a reload occurs on every fourth frame_pulse, counted from the last change of the setting.
- R8: A change of rst_interval clears both strobe counters. A strobe that arrives in the same cycle as the change neither reloads nor counts.
- R9: phase_out equals the accumulator's top 8 bits plus hue, modulo 256. It is registered, so it reflects the accumulator value from before the same clock edge.
- R10: burst_on, registered, equals burst_win AND burst_en.
- R11: In line mode, frame_pulse has no effect on reloads. In the frame modes, line_pulse has no effect on reloads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| freq_word | input | 32 | Phase increment added each clock |
| start_phase | input | 8 | Phase loaded on reset and on each reload |
| hue | input | 8 | Phase offset added to the output |
| rst_interval | input | 2 | Reload schedule: 0 never, 1 two lines, 2 two frames, 3 four frames |
| line_pulse | input | 1 | One-cycle line boundary strobe |
| frame_pulse | input | 1 | One-cycle frame boundary strobe |
| burst_win | input | 1 | High during the color-burst interval |
| burst_en | input | 1 | Allows subcarrier during the burst interval |
| phase_out | output | 8 | Subcarrier phase for the sine lookup |
| burst_on | output | 1 | Burst window qualified by burst_en |

## Verification
The assertions take three things for granted. All inputs carry known values from the first cycle of reset. The line and frame strobes are plain one-cycle pulses. A change of rst_interval is a level change seen at a single clock edge. The stimulus meets these by having one task drive every input on the falling edge. Strobes are raised for one call at a time, and settings change only between calls. The scoreboard model is written from the requirements. It places strobes on the same cycle as a setting change, and it sends frame strobes in line mode and line strobes in frame mode.

// File: rtl/sc_nco_pkg.sv
// Package: shared types for the subcarrier phase generator.
// Assumes the two-bit interval field keeps the encoding listed below.
package sc_nco_pkg;
    typedef enum logic [1:0] {
        SC_RST_NEVER  = 2'd0,
        SC_RST_2LINE  = 2'd1,
        SC_RST_2FRAME = 2'd2,
        SC_RST_4FRAME = 2'd3
    } sc_rst_mode_e;
endpackage

// File: rtl/sc_reset_sched.sv
// Module: sc_reset_sched
// Divides line and frame strobes to decide when the phase accumulator is
// reloaded. Assumes the strobes last one cycle each. When the mode differs
// from the one registered last cycle, both counters restart and no reload
// is issued in that cycle.
module sc_reset_sched
    import sc_nco_pkg::*;
#(
    parameter int LINE_DIV  = 2,
    parameter int FRM_DIV_A = 2,
    parameter int FRM_DIV_B = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  sc_rst_mode_e mode,
    input  logic         line_pulse,
    input  logic         frame_pulse,
    output logic         reload
);
    localparam int LC_W = (LINE_DIV  > 1) ? $clog2(LINE_DIV)  : 1;
    localparam int FC_W = (FRM_DIV_B > 1) ? $clog2(FRM_DIV_B) : 1;
    localparam logic [LC_W-1:0] LC_LAST = LC_W'(LINE_DIV - 1);
    localparam logic [FC_W-1:0] FC_LAST = FC_W'(FRM_DIV_B - 1);
    localparam logic [FC_W-1:0] FA_DIV  = FC_W'(FRM_DIV_A);
    localparam logic [FC_W-1:0] FA_LAST = FC_W'(FRM_DIV_A - 1);

    sc_rst_mode_e    mode_q;
    logic [LC_W-1:0] line_cnt;
    logic [FC_W-1:0] frm_cnt;
    logic            mode_chg;

    // Decide whether this cycle's strobe completes a reload interval.
    always_comb begin
        mode_chg = (mode != mode_q);
        reload   = 1'b0;
        if (!mode_chg) begin
            unique case (mode)
                SC_RST_NEVER:  reload = 1'b0;
                SC_RST_2LINE:  reload = line_pulse && (line_cnt == LC_LAST);
                SC_RST_2FRAME: reload = frame_pulse && ((frm_cnt % FA_DIV) == FA_LAST);
                SC_RST_4FRAME: reload = frame_pulse && (frm_cnt == FC_LAST);
                default:       reload = 1'b0;
            endcase
        end
    end

    // Track the mode and advance the strobe counters; restart them on a mode change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= SC_RST_NEVER;
            line_cnt <= '0;
            frm_cnt  <= '0;
        end else begin
            mode_q <= mode;
            if (mode_chg) begin
                line_cnt <= '0;
                frm_cnt  <= '0;
            end else begin
                if (line_pulse)
                    line_cnt <= (line_cnt == LC_LAST) ? '0 : line_cnt + LC_W'(1);
                if (frame_pulse)
                    frm_cnt  <= (frm_cnt == FC_LAST) ? '0 : frm_cnt + FC_W'(1);
            end
        end
    end

    // R4
    never_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SC_RST_NEVER) |-> !reload);

    // R8
    mode_chg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != $past(mode)) |-> !reload);

    // R11
    line_mode_needs_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == SC_RST_2LINE) && !line_pulse) |-> !reload);

    // R11
    frame_mode_needs_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == SC_RST_2FRAME || mode == SC_RST_4FRAME) && !frame_pulse) |-> !reload);
endmodule

// File: rtl/sc_phase_acc.sv
// Module: sc_phase_acc
// Phase accumulator. Adds the frequency word each clock, or loads the start
// phase into the top bits with the lower bits cleared on reset or reload.
// Assumes start_phase is stable while reset is held.
module sc_phase_acc #(
    parameter int ACC_W = 32,
    parameter int PH_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] freq_word,
    input  logic [PH_W-1:0]  start_phase,
    input  logic             reload,
    output logic [PH_W-1:0]  acc_top
);
    localparam int LO_W = ACC_W - PH_W;

    logic [ACC_W-1:0] acc;

    // Load the start phase or step the phase by the frequency word.
    always_ff @(posedge clk) begin
        if (!rst_n || reload)
            acc <= {start_phase, {LO_W{1'b0}}};
        else
            acc <= acc + freq_word;
    end

    assign acc_top = acc[ACC_W-1 -: PH_W];

    // R3
    reload_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (acc == {$past(start_phase), {LO_W{1'b0}}}));

    // R2
    acc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reload |=> (acc == $past(acc) + $past(freq_word)));
endmodule

// File: rtl/sc_phase_out.sv
// Module: sc_phase_out
// Output stage. Adds the hue offset to the phase (wrapping modulo 2^PH_W)
// and qualifies the burst window with the burst enable. Both outputs are
// registered and cleared by reset.
module sc_phase_out #(
    parameter int PH_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PH_W-1:0] acc_top,
    input  logic [PH_W-1:0] hue,
    input  logic            burst_win,
    input  logic            burst_en,
    output logic [PH_W-1:0] phase_out,
    output logic            burst_on
);
    // Register the hue-shifted phase and the gated burst flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_out <= '0;
            burst_on  <= 1'b0;
        end else begin
            phase_out <= acc_top + hue;
            burst_on  <= burst_win & burst_en;
        end
    end

    // R10
    burst_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !burst_en |=> !burst_on);

    // R10
    burst_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !burst_win |=> !burst_on);
endmodule

// File: rtl/sc_phase_nco.sv
// Module: sc_phase_nco (top)
// Color subcarrier phase generator. Contains the reload scheduler, the
// phase accumulator and the registered output stage. Assumes the line and
// frame strobes are synchronous to clk and last one cycle each.
module sc_phase_nco
    import sc_nco_pkg::*;
#(
    parameter int ACC_W = 32,
    parameter int PH_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] freq_word,
    input  logic [PH_W-1:0]  start_phase,
    input  logic [PH_W-1:0]  hue,
    input  logic [1:0]       rst_interval,
    input  logic             line_pulse,
    input  logic             frame_pulse,
    input  logic             burst_win,
    input  logic             burst_en,
    output logic [PH_W-1:0]  phase_out,
    output logic             burst_on
);
    logic         reload;
    logic [PH_W-1:0] acc_top;
    sc_rst_mode_e mode;

    assign mode = sc_rst_mode_e'(rst_interval);

    sc_reset_sched #(
        .LINE_DIV (2),
        .FRM_DIV_A(2),
        .FRM_DIV_B(4)
    ) u_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .line_pulse (line_pulse),
        .frame_pulse(frame_pulse),
        .reload     (reload)
    );

    sc_phase_acc #(
        .ACC_W(ACC_W),
        .PH_W (PH_W)
    ) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .freq_word  (freq_word),
        .start_phase(start_phase),
        .reload     (reload),
        .acc_top    (acc_top)
    );

    sc_phase_out #(
        .PH_W(PH_W)
    ) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_top  (acc_top),
        .hue      (hue),
        .burst_win(burst_win),
        .burst_en (burst_en),
        .phase_out(phase_out),
        .burst_on (burst_on)
    );
endmodule

// File: tb/tb_sc_phase_nco.sv
// Scoreboard bench: the step task drives one cycle and queues the expected
// outputs; the monitor pops them at the falling edge and compares.
module tb_sc_phase_nco;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] freq_word;
    logic [7:0]  start_phase, hue, phase_out;
    logic [1:0]  rst_interval;
    logic        line_pulse, frame_pulse, burst_win, burst_en, burst_on;

    always #10 clk = ~clk;

    sc_phase_nco dut (
        .clk(clk), .rst_n(rst_n), .freq_word(freq_word), .start_phase(start_phase),
        .hue(hue), .rst_interval(rst_interval), .line_pulse(line_pulse),
        .frame_pulse(frame_pulse), .burst_win(burst_win), .burst_en(burst_en),
        .phase_out(phase_out), .burst_on(burst_on)
    );

    typedef struct {
        logic [7:0] ph;
        logic       bo;
        string      tag;
    } exp_t;

    exp_t sbq[$];
    exp_t mon_e;
    int   n_chk = 0;
    int   n_bad = 0;

    logic [31:0] c_freq = 32'h21F07C1F;
    logic [7:0]  c_sp   = 8'hF9;
    logic [7:0]  c_hue  = 8'h00;
    logic [1:0]  c_mode = 2'd0;
    logic        c_be   = 1'b0;

    logic [31:0] m_acc;
    logic [1:0]  m_mq;
    logic        m_lc;
    logic [1:0]  m_fc;

    task automatic chk8(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s phase actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic chk1(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s burst actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // Hold reset for a few edges, check the reset state, and reset the model.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; freq_word = c_freq; start_phase = c_sp; hue = c_hue;
        rst_interval = c_mode; burst_en = c_be;
        line_pulse = 1'b0; frame_pulse = 1'b0; burst_win = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk8("R1", phase_out, 8'h00);
        chk1("R1", burst_on, 1'b0);
        m_acc = {c_sp, 24'h0}; m_mq = 2'd0; m_lc = 1'b0; m_fc = 2'd0;
    endtask

    // Drive one cycle, predict its outputs from the requirements, and queue them.
    task automatic step(logic l, logic f, logic b, string tag);
        exp_t e;
        logic chg, rl;
        @(negedge clk);
        rst_n = 1'b1; freq_word = c_freq; start_phase = c_sp; hue = c_hue;
        rst_interval = c_mode; burst_en = c_be;
        line_pulse = l; frame_pulse = f; burst_win = b;
        e.ph  = m_acc[31:24] + c_hue;
        e.bo  = b & c_be;
        e.tag = tag;
        chg = (c_mode != m_mq);
        rl  = 1'b0;
        if (!chg) begin
            case (c_mode)
                2'd1: rl = l && m_lc;
                2'd2: rl = f && m_fc[0];
                2'd3: rl = f && (m_fc == 2'd3);
                default: rl = 1'b0;
            endcase
        end
        if (rl) m_acc = {c_sp, 24'h0};
        else    m_acc = m_acc + c_freq;
        if (chg) begin
            m_lc = 1'b0; m_fc = 2'd0;
        end else begin
            if (l) m_lc = ~m_lc;
            if (f) m_fc = m_fc + 2'd1;
        end
        m_mq = c_mode;
        @(posedge clk);
        #1;
        sbq.push_back(e);
    endtask

    // Monitor: compare the design outputs against the oldest queued prediction.
    always @(negedge clk) begin
        if (sbq.size() > 0) begin
            mon_e = sbq.pop_front();
            chk8(mon_e.tag, phase_out, mon_e.ph);
            chk1(mon_e.tag, burst_on, mon_e.bo);
        end
    end

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state and the first value after release
        c_hue = 8'h05;
        do_reset();
        step(1'b0, 1'b0, 1'b0, "R1");
        // R2: free accumulation at the 3.58 MHz word
        c_hue = 8'h00;
        for (int i = 0; i < 30; i++) step(1'b0, 1'b0, 1'b0, "R2");
        // R4: never mode ignores both strobes
        for (int i = 0; i < 30; i++) step(i % 3 == 0, i % 4 == 1, 1'b0, "R4");
        // R9: hue offset wraps, at the 4.43 MHz word
        c_hue = 8'hC0; c_freq = 32'h2A098ACB;
        for (int i = 0; i < 25; i++) step(1'b0, 1'b0, 1'b0, "R9");
        // R5 and R3: reload on every second line strobe
        c_hue = 8'h00; c_freq = 32'h21F07C1F; c_sp = 8'hF9; c_mode = 2'd1;
        for (int i = 0; i < 40; i++) step(i % 5 == 2, 1'b0, 1'b0, "R5");
        // R11: frame strobes do nothing in line mode
        for (int i = 0; i < 30; i++) step(1'b0, i % 4 == 0, 1'b0, "R11");
        // R6 and R3: reload on every second frame strobe
        c_mode = 2'd2; c_sp = 8'hD9; c_freq = 32'h2A098ACB;
        for (int i = 0; i < 45; i++) step(1'b0, i % 7 == 3, 1'b0, "R6");
        // R11: line strobes do nothing in frame mode
        for (int i = 0; i < 30; i++) step(i % 3 == 0, 1'b0, 1'b0, "R11");
        // R7: reload on every fourth frame strobe
        c_mode = 2'd3; c_sp = 8'h40;
        for (int i = 0; i < 60; i++) step(1'b0, i % 6 == 1, 1'b0, "R7");
        // R8: a strobe on the cycle of a mode change neither counts nor reloads
        c_mode = 2'd2;
        step(1'b0, 1'b1, 1'b0, "R8");
        for (int i = 0; i < 6; i++) step(1'b0, 1'b0, 1'b0, "R8");
        c_mode = 2'd3;
        step(1'b0, 1'b1, 1'b0, "R8");
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, "R8");
        c_mode = 2'd2;
        for (int i = 0; i < 20; i++) step(1'b0, i % 5 == 2, 1'b0, "R8");
        // R10: burst qualification under both enables
        c_be = 1'b0;
        for (int i = 0; i < 10; i++) step(1'b0, 1'b0, i % 2 == 0, "R10");
        c_be = 1'b1;
        for (int i = 0; i < 10; i++) step(1'b0, 1'b0, i % 3 != 0, "R10");
        // R1: a second reset with a new start phase and hue
        c_sp = 8'h7E; c_hue = 8'h91; c_mode = 2'd0;
        do_reset();
        step(1'b0, 1'b0, 1'b0, "R1");
        step(1'b0, 1'b0, 1'b0, "R2");
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule